// File: doc/BRIEF.md
# Indirect Subsystem Register Bridge

The bridge sits on a 32-bit memory-mapped host bus and gives software access to a byte-wide register file that lives in a slow subsystem. Subsystem registers are not mapped directly. The host loads a command word and a data word, and the bridge runs one subsystem transfer. The command word holds the target register address, a direction bit and byte enables. While the transfer runs, the bridge keeps a busy flag set, and software polls that flag before it touches the command or data registers again.

The subsystem is reached over a fixed-latency handshake. The address and write byte stay stable for the whole transfer. A single-cycle commit strobe in the last busy cycle performs the write, or captures the read byte into the lower data register. The bridge also holds a two-bit interrupt flag register and a matching enable register. Bit 1 latches rising edges of the subsystem interrupt line. Bit 0 latches the completion of each transfer. The combined interrupt output is raised when any flag bit is set while its enable bit is set.

Top module: `sreg_bridge`

## Requirements
- R1: After reset the control, lower data, upper data, interrupt enable and interrupt flag registers read 0, busy is clear and irq_o is low. Offset 0x00 reads the ID_VALUE parameter.
- R2: The control register (offset 0x04) stores the subsystem address in bits 7:0, lower byte enables in 19:16, upper byte enables in 23:20, direction in 24 (1 = read) and size in 25. Bit 31 reads the read-only busy flag. All other bits read 0.
- R3: A control write with bit 24 set, made while idle, starts a read transfer. Busy (control bit 31) then reads 1 for exactly LAT cycles.
- R4: A control write with bit 24 clear starts nothing. A following write to the lower data register (offset 0x08) starts a write transfer, which commits data bits 7:0 to the addressed subsystem register.
- R5: Bit 16 enables the byte lane. When bit 16 is set, a completed read places the subsystem byte in lower data bits 7:0 and leaves bits 31:8 unchanged. When bit 16 is clear, a read leaves the lower data register unchanged and a write does not commit.
- R6: Host writes to the control or lower data register while busy is set are ignored.
- R7: The upper data register (offset 0x0C) stores and returns any 32-bit value.
- R8: Interrupt flag bit 1 (offset 0x14) is set on a rising edge of sub_irq_i, and bit 0 is set when a transfer completes. Writing 1 to a flag bit clears it. A set in the same cycle as a clear wins. A source that stays high does not set the flag again.
- R9: irq_o is high exactly when some flag bit is set while its enable bit (offset 0x10, same bit positions) is set.
- R10: Each transfer produces exactly one sub_stb_o pulse, in its last busy cycle. sub_stb_o is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsel_i | input | 1 | Host access select |
| hwr_i | input | 1 | Host write (1) or read (0) |
| haddr_i | input | 5 | Host byte offset |
| hwdata_i | input | 32 | Host write data |
| hrdata_o | output | 32 | Host read data (combinational) |
| sub_stb_o | output | 1 | Subsystem commit strobe |
| sub_we_o | output | 1 | Subsystem write qualifier on the strobe |
| sub_addr_o | output | 8 | Subsystem register address |
| sub_wdata_o | output | 8 | Subsystem write byte |
| sub_rdata_i | input | 8 | Subsystem read byte, valid while the address is stable |
| sub_irq_i | input | 1 | Subsystem interrupt source |
| irq_o | output | 1 | Gated interrupt output |

## Verification
The assertions assume that the host applies each access for one clock cycle with select and write held stable. They also assume that the subsystem read byte depends only on the address the bridge presents. The interrupt check assumes the enable register is not rewritten in the cycle where the subsystem line rises. The bench keeps to these assumptions: its host tasks drive one access per cycle on the falling edge, and its subsystem model is a byte array indexed by sub_addr_o. Random transfers use random addresses, data and directions. Software would normally wait for busy to clear, so the bench writes during busy only in directed cases.

// File: rtl/sreg_bridge_pkg.sv
package sreg_bridge_pkg;
  localparam int HDW     = 32;
  localparam int HAW     = 5;
  localparam int SAW     = 8;
  localparam int SDW     = 8;
  localparam int NIRQ    = 2;

  // word indices of host registers (byte offset >> 2)
  localparam logic [2:0] W_ID   = 3'd0;
  localparam logic [2:0] W_CTL  = 3'd1;
  localparam logic [2:0] W_LDAT = 3'd2;
  localparam logic [2:0] W_UDAT = 3'd3;
  localparam logic [2:0] W_IEN  = 3'd4;
  localparam logic [2:0] W_IFLG = 3'd5;

  localparam int B_BUSY  = 31;
  localparam int B_SIZE  = 25;
  localparam int B_DIR   = 24;
  localparam int B_BENHI = 20;
  localparam int B_BENLO = 16;

  typedef struct packed {
    logic           size;
    logic           rd;
    logic [3:0]     ben_hi;
    logic [3:0]     ben_lo;
    logic [SAW-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/sreg_seq.sv
module sreg_seq #(
  parameter int LAT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic rd_i,
  input  logic lane_i,
  output logic busy_o,
  output logic stb_o,
  output logic we_o,
  output logic cap_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic          busy_q, rd_q, lane_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      lane_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q <= 1'b1;
        rd_q   <= rd_i;
        lane_q <= lane_i;
        cnt_q  <= CNT_INIT;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign stb_o  = busy_q && (cnt_q == '0);
  assign we_o   = stb_o && !rd_q && lane_q;
  assign cap_o  = stb_o && rd_q && lane_q;
endmodule

// File: rtl/sreg_irq.sv
module sreg_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            en_wr_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] flg_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q, flg_q, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      src_q <= '0;
    end else begin
      src_q <= src_i;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic set_w, clr_w;
    assign set_w = src_i[i] && !src_q[i];
    assign clr_w = clr_wr_i && wdata_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flg_q[i] <= 1'b0;
      else if (set_w) flg_q[i] <= 1'b1;  // set beats clear
      else if (clr_w) flg_q[i] <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign flg_o = flg_q;
  assign irq_o = |(flg_q & en_q);
endmodule

// File: rtl/sreg_bridge.sv
module sreg_bridge
  import sreg_bridge_pkg::*;
#(
  parameter int          LAT      = 6,
  parameter logic [31:0] ID_VALUE = 32'h5B_1D_0001
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hsel_i,
  input  logic           hwr_i,
  input  logic [HAW-1:0] haddr_i,
  input  logic [HDW-1:0] hwdata_i,
  output logic [HDW-1:0] hrdata_o,
  output logic           sub_stb_o,
  output logic           sub_we_o,
  output logic [SAW-1:0] sub_addr_o,
  output logic [SDW-1:0] sub_wdata_o,
  input  logic [SDW-1:0] sub_rdata_i,
  input  logic           sub_irq_i,
  output logic           irq_o
);
  cmd_t            cmd_q;
  logic [HDW-1:0]  ldat_q, udat_q;
  logic            busy_q, cap_w, done_w;
  logic [2:0]      widx;
  logic            wr_w, ctl_wr, ldat_wr, launch_w, seq_rd, seq_lane;
  logic [NIRQ-1:0] ien_q, iflg_q;

  assign widx    = haddr_i[HAW-1:2];
  assign wr_w    = hsel_i && hwr_i;
  assign ctl_wr  = wr_w && (widx == W_CTL)  && !busy_q;
  assign ldat_wr = wr_w && (widx == W_LDAT) && !busy_q;

  assign launch_w = (ctl_wr && hwdata_i[B_DIR]) || (ldat_wr && !cmd_q.rd);
  assign seq_rd   = ctl_wr ? hwdata_i[B_DIR]   : cmd_q.rd;
  assign seq_lane = ctl_wr ? hwdata_i[B_BENLO] : cmd_q.ben_lo[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      ldat_q <= '0;
      udat_q <= '0;
    end else begin
      if (ctl_wr) begin
        cmd_q.size   <= hwdata_i[B_SIZE];
        cmd_q.rd     <= hwdata_i[B_DIR];
        cmd_q.ben_hi <= hwdata_i[B_BENHI +: 4];
        cmd_q.ben_lo <= hwdata_i[B_BENLO +: 4];
        cmd_q.addr   <= hwdata_i[SAW-1:0];
      end
      if (ldat_wr) ldat_q <= hwdata_i;
      else if (cap_w) ldat_q[SDW-1:0] <= sub_rdata_i;
      if (wr_w && widx == W_UDAT) udat_q <= hwdata_i;
    end
  end

  sreg_seq #(.LAT(LAT)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch_w),
    .rd_i     (seq_rd),
    .lane_i   (seq_lane),
    .busy_o   (busy_q),
    .stb_o    (done_w),
    .we_o     (sub_we_o),
    .cap_o    (cap_w)
  );

  assign sub_stb_o   = done_w;
  assign sub_addr_o  = cmd_q.addr;
  assign sub_wdata_o = ldat_q[SDW-1:0];

  sreg_irq #(.NSRC(NIRQ)) irq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    ({sub_irq_i, done_w}),
    .en_wr_i  (wr_w && widx == W_IEN),
    .clr_wr_i (wr_w && widx == W_IFLG),
    .wdata_i  (hwdata_i[NIRQ-1:0]),
    .en_o     (ien_q),
    .flg_o    (iflg_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    hrdata_o = '0;
    if (hsel_i && !hwr_i) begin
      unique case (widx)
        W_ID:   hrdata_o = ID_VALUE;
        W_CTL: begin
          hrdata_o[B_BUSY]         = busy_q;
          hrdata_o[B_SIZE]         = cmd_q.size;
          hrdata_o[B_DIR]          = cmd_q.rd;
          hrdata_o[B_BENHI +: 4]   = cmd_q.ben_hi;
          hrdata_o[B_BENLO +: 4]   = cmd_q.ben_lo;
          hrdata_o[SAW-1:0]        = cmd_q.addr;
        end
        W_LDAT: hrdata_o = ldat_q;
        W_UDAT: hrdata_o = udat_q;
        W_IEN:  hrdata_o[NIRQ-1:0] = ien_q;
        W_IFLG: hrdata_o[NIRQ-1:0] = iflg_q;
        default: hrdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sreg_bridge_chk.sv
module sreg_bridge_chk #(
  parameter int LAT = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hsel_i,
  input logic       hwr_i,
  input logic [4:0] haddr_i,
  input logic [31:0] hwdata_i,
  input logic       busy_q,
  input logic       sub_stb_o,
  input logic [7:0] sub_addr_o,
  input logic       sub_irq_i,
  input logic [1:0] ien_q,
  input logic       irq_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R3
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsel_i && hwr_i && haddr_i[4:2] == 3'd1 && hwdata_i[24] && !busy_q) |=> busy_q);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (run_q == 16'(LAT)));

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || $stable(sub_addr_o)));

  // R10
  stb_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_stb_o |=> !busy_q);

  // R10
  stb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sub_stb_o);

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sub_irq_i) && ien_q[1] && !(hsel_i && hwr_i && haddr_i[4:2] == 3'd4)) |=> irq_o);
endmodule

bind sreg_bridge sreg_bridge_chk #(.LAT(LAT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsel_i     (hsel_i),
  .hwr_i      (hwr_i),
  .haddr_i    (haddr_i),
  .hwdata_i   (hwdata_i),
  .busy_q     (busy_q),
  .sub_stb_o  (sub_stb_o),
  .sub_addr_o (sub_addr_o),
  .sub_irq_i  (sub_irq_i),
  .ien_q      (ien_q),
  .irq_o      (irq_o)
);

// File: tb/sreg_bridge_tb_top.sv
module sreg_bridge_tb_top;
  localparam int          LAT = 6;
  localparam logic [31:0] IDV = 32'h5B_1D_0001;
  localparam logic [4:0] O_ID = 5'h00, O_CTL = 5'h04, O_LD = 5'h08,
                         O_UD = 5'h0C, O_IEN = 5'h10, O_IFL = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsel = 1'b0, hwr = 1'b0, sub_irq = 1'b0;
  logic [4:0] haddr = '0;
  logic [31:0] hwdata = '0, hrdata;
  logic sub_stb, sub_we, irq;
  logic [7:0] sub_addr, sub_wdata, sub_rdata;
  logic [7:0] sub_mem [256];
  logic [7:0] exp_mem [256];
  int n_cmp = 0, n_bad = 0, n_stb = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sreg_bridge #(.LAT(LAT), .ID_VALUE(IDV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .hwr_i(hwr), .haddr_i(haddr),
    .hwdata_i(hwdata), .hrdata_o(hrdata), .sub_stb_o(sub_stb), .sub_we_o(sub_we),
    .sub_addr_o(sub_addr), .sub_wdata_o(sub_wdata), .sub_rdata_i(sub_rdata),
    .sub_irq_i(sub_irq), .irq_o(irq));

  assign sub_rdata = sub_mem[sub_addr];
  always @(posedge clk) begin
    if (sub_stb) n_stb <= n_stb + 1;
    if (sub_stb && sub_we) sub_mem[sub_addr] <= sub_wdata;
  end

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 11) ^ 8'h5C);
  endfunction

  function automatic logic [31:0] ctl_word(logic rd, logic lane, logic [7:0] a);
    return (32'(rd) << 24) | (32'(lane) << 16) | 32'(a);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic hw(logic [4:0] a, logic [31:0] d);
    hsel = 1; hwr = 1; haddr = a; hwdata = d;
    @(negedge clk);
    hsel = 0; hwr = 0;
  endtask

  task automatic hr(logic [4:0] a, output logic [31:0] d);
    hsel = 1; hwr = 0; haddr = a;
    #1 d = hrdata;
    hsel = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      hr(O_CTL, v);
      if (!v[31]) break;
      n++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got %0d expected below 100000", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] v, exp_ld;
    int n, s0;
    void'($urandom(1234));
    for (int i = 0; i < 256; i++) begin
      sub_mem[i] = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    hr(O_ID, v);  chk("R1 id", v, IDV);
    hr(O_CTL, v); chk("R1 ctl", v, 0);
    hr(O_LD, v);  chk("R1 ldata", v, 0);
    hr(O_UD, v);  chk("R1 udata", v, 0);
    hr(O_IEN, v); chk("R1 ien", v, 0);
    hr(O_IFL, v); chk("R1 iflg", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 field layout, unused and busy bits read 0
    hw(O_CTL, 32'h82FA_5A3C);
    hr(O_CTL, v); chk("R2 ctl fields", v, 32'h02FA_003C);

    // R4 write transfer
    hw(O_CTL, ctl_word(0, 1, 8'h42));
    hr(O_CTL, v); chk("R4 no launch on ctl", 32'(v[31]), 0);
    s0 = n_stb;
    hw(O_LD, 32'h1234_56A5);
    exp_ld = 32'h1234_56A5; exp_mem[8'h42] = 8'hA5;
    wait_idle(n);
    chk("R3 busy length write", n, LAT);
    chk("R4 committed byte", 32'(sub_mem[8'h42]), 32'(exp_mem[8'h42]));
    chk("R10 one strobe", n_stb - s0, 1);

    // R3 R5 read with lane enabled
    s0 = n_stb;
    hw(O_CTL, ctl_word(1, 1, 8'h42));
    wait_idle(n);
    chk("R3 busy length read", n, LAT);
    hr(O_LD, v); chk("R5 read byte", v, {exp_ld[31:8], 8'hA5});
    exp_ld = v;
    chk("R10 one strobe read", n_stb - s0, 1);

    // R5 read with lane disabled
    hw(O_CTL, ctl_word(1, 0, 8'h10));
    wait_idle(n);
    hr(O_LD, v); chk("R5 read lane off", v, exp_ld);

    // R5 write with lane disabled
    hw(O_CTL, ctl_word(0, 0, 8'h11));
    hw(O_LD, 32'h0000_0077);
    exp_ld = 32'h77;
    wait_idle(n);
    chk("R5 write lane off", 32'(sub_mem[8'h11]), 32'(seed_val(8'h11)));

    // R6 writes during busy ignored
    hw(O_CTL, ctl_word(1, 1, 8'h20));
    hw(O_CTL, ctl_word(0, 1, 8'h99));
    hw(O_LD, 32'hDEAD_BEEF);
    wait_idle(n);
    hr(O_CTL, v); chk("R6 ctl kept", v, ctl_word(1, 1, 8'h20));
    hr(O_LD, v);  chk("R6 ldata kept", v, {exp_ld[31:8], exp_mem[8'h20]});
    exp_ld = v;

    // R7 upper data
    hw(O_UD, 32'hCAFE_F00D);
    hr(O_UD, v); chk("R7 udata", v, 32'hCAFE_F00D);

    // R8 R9 interrupts
    hr(O_IFL, v); chk("R8 done flag", v, 1);
    chk("R9 masked", 32'(irq), 0);
    hw(O_IFL, 3);
    hr(O_IFL, v); chk("R8 w1c", v, 0);
    hw(O_IEN, 1);
    hw(O_CTL, ctl_word(1, 1, 8'h05));
    wait_idle(n);
    chk("R9 irq on done", 32'(irq), 1);
    hw(O_IFL, 2);
    hr(O_IFL, v); chk("R8 clear other bit", v, 1);
    hw(O_IFL, 1);
    chk("R9 irq drop", 32'(irq), 0);
    hw(O_IEN, 2);
    sub_irq = 1;
    @(negedge clk);
    hr(O_IFL, v); chk("R8 rise sets", v, 2);
    chk("R9 irq sub", 32'(irq), 1);
    hw(O_IFL, 2);
    hr(O_IFL, v); chk("R8 level no reset", v, 0);
    sub_irq = 0;
    @(negedge clk);
    sub_irq = 1;
    hw(O_IFL, 2);
    hr(O_IFL, v); chk("R8 set wins", v, 2);
    sub_irq = 0;
    hw(O_IFL, 3);
    hw(O_IEN, 0);

    // random transfers
    for (int t = 0; t < 80; t++) begin
      logic [7:0] a;
      logic rd;
      logic [31:0] d;
      a = 8'($urandom);
      rd = 1'($urandom);
      d = $urandom;
      s0 = n_stb;
      if (rd) begin
        hw(O_CTL, ctl_word(1, 1, a));
        wait_idle(n);
        hr(O_LD, v);
        chk("R5 random read", v, {exp_ld[31:8], exp_mem[a]});
        exp_ld = v;
      end else begin
        hw(O_CTL, ctl_word(0, 1, a));
        hw(O_LD, d);
        exp_ld = d; exp_mem[a] = d[7:0];
        wait_idle(n);
        chk("R4 random write", 32'(sub_mem[a]), 32'(exp_mem[a]));
      end
      chk("R3 random busy", n, LAT);
      chk("R10 random strobe", n_stb - s0, 1);
    end
    hr(O_IFL, v); chk("R8 done flag after random", v, 1);

    summary();
  end
endmodule